// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

The block is a watchdog timer that walks through four timeout stages in order, 0 to 3, and then wraps back to stage 0. A programmable prescaler divides the system clock into watchdog ticks. Each stage counts ticks up to its own 32-bit limit. When that limit is reached, the stage's 2-bit action code decides what happens: nothing, an interrupt, a CPU reset pulse, or a system reset pulse. The sequence then moves on to the next stage with a cleared count. Software keeps the watchdog quiet by writing the restart register before stage 0 runs out.

All configuration goes through a simple 32-bit register port. Writes are single-cycle strobes and reads are combinational. The control, prescale, timeout and restart registers can only be changed while the key register holds the unlock constant. This guards the watchdog against stray writes. The two reset outputs are pulses whose length comes from a 3-bit code looked up in a fixed table of widths.

Top module: `stage_watchdog`

## Requirements
- R1: Register word addresses are: 0 control, 1 prescale (bits 15:0), 2 to 5 the timeouts of stages 0 to 3, 6 restart, 7 key, 8 interrupt enable (bit 0), 9 raw interrupt (bit 0), 10 masked interrupt (bit 0, read only). The control register has master enable at bit 0 and CPU-reset enable at bit 1. The action of stage k sits at bits 2k+3:2k+2, with 0 off, 1 interrupt, 2 CPU reset and 3 system reset. The CPU pulse code sits at bits 12:10 and the system pulse code at bits 15:13. Reads of control, prescale, timeout and key return the last accepted write.
- R2: After reset all three outputs are low. Control reads 0x2400 and prescale reads 1. The timeouts read 26000000, 134217727, 1048575 and 1048575 for stages 0 to 3. The key reads 0x50D83AA1, so the block starts unlocked. Interrupt enable reads 0.
- R3: Suppose the master enable is written to 1 at clock edge W while it was 0. Stage 0 then expires at edge W + P*T0, where P is the prescale value (0 counts as 1) and T0 is the stage 0 timeout. While the enable is 0 no stage expires, and the sequence is held at stage 0 with a cleared count.
- R4: After stage k expires at edge E, stage k+1 expires at edge E + P*T(k+1). After stage 3, the sequence goes back to stage 0. A stage whose action is off still takes its full timeout.
- R5: Suppose the restart register is written at edge F. The sequence returns to stage 0 with a cleared count, and the next expiry is at F + P*T0. Any expiry that would have come earlier does not happen.
- R6: An expiring stage with action 1 sets the raw interrupt bit at the expiry edge. The interrupt output and the masked bit equal raw AND enable. Writing 1 to bit 0 of address 9 clears the raw bit. A new expiry in the same cycle takes precedence over the clear.
- R7: An expiring stage with action 2 starts a CPU reset pulse at the expiry edge only when CPU-reset enable is 1. When CPU-reset enable is 0 the CPU reset output stays low.
- R8: An expiring stage with action 3 starts a system reset pulse at the expiry edge.
- R9: Pulse width codes 0 to 7 give high times of 8, 16, 24, 32, 40, 64, 128 and 256 clock cycles (8 cycles per 100 ns). A new start while a pulse is active restarts the width.
- R10: While the key differs from 0x50D83AA1, writes to addresses 0 to 6 are ignored, and that includes the restart register. Writes to the key, the interrupt enable and the interrupt clear are always accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Masked watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Every result lands on a clock edge that can be counted from the edge that sampled a write. A stage expiry falls a whole number of prescaled ticks after the enable or restart write. Interrupt and pulse outputs change at the expiry edge itself, and a pulse falls exactly its table width later. Register reads are due in the same cycle the address is presented. The driver records each write's edge number from a free-running cycle count and queues the start edge and width it expects. The monitor samples the outputs one nanosecond after each falling edge and compares every rise and fall it sees against the head of the matching queue. A pulse or interrupt that arrives early, late, with the wrong width, or with no matching entry is reported.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  localparam int REG_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int NSTAGE  = 4;
  localparam int STAGE_W = $clog2(NSTAGE);
  localparam int CODE_W  = 3;

  localparam logic [REG_W-1:0] UNLOCK_KEY = 32'h50D8_3AA1;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_TMO0   = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEED   = 4'd6;
  localparam logic [ADDR_W-1:0] A_KEY    = 4'd7;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IRQRAW = 4'd9;
  localparam logic [ADDR_W-1:0] A_IRQST  = 4'd10;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } act_e;

  typedef struct packed {
    logic [CODE_W-1:0]         sys_len;
    logic [CODE_W-1:0]         cpu_len;
    logic [NSTAGE-1:0][1:0]    act;
    logic                      cpu_rst_en;
    logic                      enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = ctrl_t'(16'h2400);

endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int TMO_W   = 32,
  parameter logic [NSTAGE-1:0][TMO_W-1:0] TMO_DEF = {32'd1048575, 32'd1048575,
                                                      32'd134217727, 32'd26000000}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  input  logic                          irq_set,
  output ctrl_t                         ctrl_o,
  output logic [PRESC_W-1:0]            presc_o,
  output logic [NSTAGE-1:0][TMO_W-1:0]  tmo_o,
  output logic                          feed_o,
  output logic                          irq_o
);

  ctrl_t                         ctrl_q, ctrl_d;
  logic [PRESC_W-1:0]            presc_q, presc_d;
  logic [NSTAGE-1:0][TMO_W-1:0]  tmo_q;
  logic [REG_W-1:0]              key_q, key_d;
  logic                          irqen_q, irqen_d;
  logic                          raw_q, raw_d;
  logic                          locked, cfg_wr;
  logic                          ctrl_we, presc_we, key_we, irqen_we, raw_clr;

  assign locked   = (key_q != UNLOCK_KEY);
  assign cfg_wr   = wr && !locked;
  assign ctrl_we  = cfg_wr && (addr == A_CTRL);
  assign presc_we = cfg_wr && (addr == A_PRESC);
  assign key_we   = wr && (addr == A_KEY);
  assign irqen_we = wr && (addr == A_IRQEN);
  assign raw_clr  = wr && (addr == A_IRQRAW) && wdata[0];
  assign feed_o   = cfg_wr && (addr == A_FEED);

  always_comb begin
    ctrl_d  = ctrl_we  ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    presc_d = presc_we ? wdata[PRESC_W-1:0]         : presc_q;
    key_d   = key_we   ? wdata                      : key_q;
    irqen_d = irqen_we ? wdata[0]                   : irqen_q;
    raw_d   = irq_set | (raw_q & ~raw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      presc_q <= PRESC_W'(1);
      key_q   <= UNLOCK_KEY;
      irqen_q <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      key_q   <= key_d;
      irqen_q <= irqen_d;
      raw_q   <= raw_d;
    end
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_tmo
    logic             we;
    logic [TMO_W-1:0] nxt;
    assign we  = cfg_wr && (addr == A_TMO0 + ADDR_W'(s));
    assign nxt = we ? wdata[TMO_W-1:0] : tmo_q[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmo_q[s] <= TMO_DEF[s];
      else        tmo_q[s] <= nxt;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CTRL_W-1:0]  = ctrl_q;
      A_PRESC:  rdata[PRESC_W-1:0] = presc_q;
      A_KEY:    rdata              = key_q;
      A_IRQEN:  rdata[0]           = irqen_q;
      A_IRQRAW: rdata[0]           = raw_q;
      A_IRQST:  rdata[0]           = raw_q & irqen_q;
      default:  rdata              = '0;
    endcase
    for (int s = 0; s < NSTAGE; s++) begin
      if (addr == A_TMO0 + ADDR_W'(s)) rdata[TMO_W-1:0] = tmo_q[s];
    end
  end

  assign ctrl_o  = ctrl_q;
  assign presc_o = presc_q;
  assign tmo_o   = tmo_q;
  assign irq_o   = raw_q & irqen_q;

  // R10: a locked port leaves control and prescale untouched
  a_r10_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && addr == A_CTRL) |=> $stable(ctrl_q));
  a_r10_locked_presc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && addr == A_PRESC) |=> $stable(presc_q));
  // R10: key writes always land
  a_r10_key_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_KEY) |=> (key_q == $past(wdata)));
  // R6: clear without a new set empties the raw bit
  a_r6_raw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_clr && !irq_set) |=> !raw_q);
  // R6: a set always wins
  a_r6_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> raw_q);

endmodule

// File: rtl/wdg_sequencer.sv
`timescale 1ns/1ps
module wdg_sequencer
  import wdg_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int TMO_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic                          cpu_rst_en,
  input  logic                          feed,
  input  logic [PRESC_W-1:0]            presc,
  input  logic [NSTAGE-1:0][TMO_W-1:0]  tmo,
  input  logic [NSTAGE-1:0][1:0]        act,
  output logic                          irq_set,
  output logic                          cpu_start,
  output logic                          sys_start
);

  logic [PRESC_W-1:0] pcnt_q, pcnt_d, presc_eff;
  logic [TMO_W-1:0]   tcnt_q, tcnt_d, tmo_cur;
  logic [STAGE_W-1:0] stage_q, stage_d, stage_inc;
  logic               tick, expire, fire;
  act_e               act_cur;

  assign presc_eff = (presc == '0) ? PRESC_W'(1) : presc;
  assign tmo_cur   = tmo[stage_q];
  assign act_cur   = act_e'(act[stage_q]);
  assign tick      = enable && (pcnt_q == presc_eff - PRESC_W'(1));
  assign expire    = tick && (({1'b0, tcnt_q} + (TMO_W+1)'(1)) >= {1'b0, tmo_cur});
  assign fire      = expire && !feed;
  assign stage_inc = (stage_q == STAGE_W'(NSTAGE-1)) ? '0 : stage_q + STAGE_W'(1);

  always_comb begin
    pcnt_d  = pcnt_q;
    tcnt_d  = tcnt_q;
    stage_d = stage_q;
    if (!enable || feed) begin
      pcnt_d  = '0;
      tcnt_d  = '0;
      stage_d = '0;
    end else if (tick) begin
      pcnt_d = '0;
      if (expire) begin
        tcnt_d  = '0;
        stage_d = stage_inc;
      end else begin
        tcnt_d = tcnt_q + TMO_W'(1);
      end
    end else begin
      pcnt_d = pcnt_q + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      tcnt_q  <= '0;
      stage_q <= '0;
    end else begin
      pcnt_q  <= pcnt_d;
      tcnt_q  <= tcnt_d;
      stage_q <= stage_d;
    end
  end

  assign irq_set   = fire && (act_cur == ACT_IRQ);
  assign cpu_start = fire && (act_cur == ACT_CPU) && cpu_rst_en;
  assign sys_start = fire && (act_cur == ACT_SYS);

  // R5: a restart leaves stage 0 with a cleared count
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (stage_q == '0 && tcnt_q == '0));
  // R4: an expiry advances one stage, wrapping after the last
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !feed) |=> (stage_q == (($past(stage_q) == STAGE_W'(NSTAGE-1)) ?
                                       STAGE_W'(0) : $past(stage_q) + STAGE_W'(1))));
  // R3: disabled sequence sits at stage 0
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (stage_q == '0 && tcnt_q == '0));
  // R3: the count never passes its limit while running
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !feed && tick && !expire) |=> (tcnt_q != '0));

endmodule

// File: rtl/wdg_pulse.sv
`timescale 1ns/1ps
module wdg_pulse
  import wdg_pkg::*;
#(
  parameter int BASE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              pulse_o
);

  localparam int LEN_W = $clog2(BASE_CYC * 32 + 1);

  function automatic logic [LEN_W-1:0] width_of(input logic [CODE_W-1:0] c);
    if (c < CODE_W'(5)) return LEN_W'(BASE_CYC * (int'(c) + 1));
    else                return LEN_W'((BASE_CYC * 8) << (int'(c) - 5));
  endfunction

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    if (start)     cnt_d = width_of(code);
    else if (busy) cnt_d = cnt_q - LEN_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = busy;

  // R9: a start drives the pulse high at the next edge
  a_r9_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pulse_o);
  // R9: an idle output stays idle without a start
  a_r9_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !pulse_o) |=> !pulse_o);

endmodule

// File: rtl/stage_watchdog.sv
`timescale 1ns/1ps
module stage_watchdog
  import wdg_pkg::*;
#(
  parameter int PRESC_W    = 16,
  parameter int TMO_W      = 32,
  parameter int PULSE_BASE = 8,
  parameter logic [NSTAGE-1:0][TMO_W-1:0] TMO_DEF = {32'd1048575, 32'd1048575,
                                                      32'd134217727, 32'd26000000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);

  ctrl_t                        ctrl;
  logic [PRESC_W-1:0]           presc;
  logic [NSTAGE-1:0][TMO_W-1:0] tmo;
  logic                         feed, irq_set, cpu_start, sys_start;
  logic [1:0]                   starts, pulses;
  logic [1:0][CODE_W-1:0]       codes;

  wdg_regs #(.PRESC_W(PRESC_W), .TMO_W(TMO_W), .TMO_DEF(TMO_DEF)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .irq_set (irq_set),
    .ctrl_o  (ctrl),
    .presc_o (presc),
    .tmo_o   (tmo),
    .feed_o  (feed),
    .irq_o   (irq_o)
  );

  wdg_sequencer #(.PRESC_W(PRESC_W), .TMO_W(TMO_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl.enable),
    .cpu_rst_en (ctrl.cpu_rst_en),
    .feed       (feed),
    .presc      (presc),
    .tmo        (tmo),
    .act        (ctrl.act),
    .irq_set    (irq_set),
    .cpu_start  (cpu_start),
    .sys_start  (sys_start)
  );

  assign starts = {sys_start, cpu_start};
  assign codes  = {ctrl.sys_len, ctrl.cpu_len};

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    wdg_pulse #(.BASE_CYC(PULSE_BASE)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (starts[g]),
      .code    (codes[g]),
      .pulse_o (pulses[g])
    );
  end

  assign cpu_rst_o = pulses[0];
  assign sys_rst_o = pulses[1];

endmodule

// File: tb/stage_watchdog_test.sv
`timescale 1ns/1ps
module stage_watchdog_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, cpu_rst_o, sys_rst_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int w_edge = 0;

  typedef struct { int t; int len; string req; } exp_t;
  exp_t q_irq[$];
  exp_t q_cpu[$];
  exp_t q_sys[$];

  stage_watchdog uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    w_edge = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string req, input string what);
    int v;
    rd(a, v);
    chk(v == exp, req, what, v, exp);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(bit en, bit ce, logic [1:0] a0, logic [1:0] a1,
                                     logic [1:0] a2, logic [1:0] a3,
                                     logic [2:0] cl, logic [2:0] sl);
    return {16'b0, sl, cl, a3, a2, a1, a0, ce, en};
  endfunction

  function automatic int plen(input int c);
    return (c < 5) ? 8 * (c + 1) : 64 << (c - 5);
  endfunction

  task automatic push(input int which, input int t, input int len, input string req);
    exp_t e;
    e.t = t; e.len = len; e.req = req;
    if (which == 0) q_irq.push_back(e);
    else if (which == 1) q_cpu.push_back(e);
    else q_sys.push_back(e);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compares observed edges against the scoreboard queues
  logic irq_p = 1'b0, cpu_p = 1'b0, sys_p = 1'b0;
  int   cpu_t0 = 0, sys_t0 = 0;
  always begin
    exp_t e;
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (irq_o && !irq_p) begin
        if (q_irq.size() == 0) chk(1'b0, "R6", "unexpected interrupt rise", cyc, -1);
        else begin
          e = q_irq.pop_front();
          chk(cyc == e.t, e.req, "interrupt rise edge", cyc, e.t);
        end
      end
      if (cpu_rst_o && !cpu_p) cpu_t0 = cyc;
      if (!cpu_rst_o && cpu_p) begin
        if (q_cpu.size() == 0) chk(1'b0, "R7", "unexpected CPU pulse", cpu_t0, -1);
        else begin
          e = q_cpu.pop_front();
          chk(cpu_t0 == e.t, e.req, "CPU pulse start", cpu_t0, e.t);
          chk(cyc - cpu_t0 == e.len, e.req, "CPU pulse width", cyc - cpu_t0, e.len);
        end
      end
      if (sys_rst_o && !sys_p) sys_t0 = cyc;
      if (!sys_rst_o && sys_p) begin
        if (q_sys.size() == 0) chk(1'b0, "R8", "unexpected system pulse", sys_t0, -1);
        else begin
          e = q_sys.pop_front();
          chk(sys_t0 == e.t, e.req, "system pulse start", sys_t0, e.t);
          chk(cyc - sys_t0 == e.len, e.req, "system pulse width", cyc - sys_t0, e.len);
        end
      end
    end
    irq_p = irq_o; cpu_p = cpu_rst_o; sys_p = sys_rst_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    logic [31:0] c;
    int w, f, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    chk(!irq_o && !cpu_rst_o && !sys_rst_o, "R2", "outputs low after reset",
        int'({irq_o, cpu_rst_o, sys_rst_o}), 0);
    rd_chk(4'd0, 32'h2400, "R2", "control reset");
    rd_chk(4'd1, 1, "R2", "prescale reset");
    rd_chk(4'd2, 26000000, "R2", "stage0 timeout reset");
    rd_chk(4'd3, 134217727, "R2", "stage1 timeout reset");
    rd_chk(4'd4, 1048575, "R2", "stage2 timeout reset");
    rd_chk(4'd5, 1048575, "R2", "stage3 timeout reset");
    rd_chk(4'd7, 32'h50D83AA1, "R2", "key reset");
    rd_chk(4'd8, 0, "R2", "interrupt enable reset");

    // R3/R4/R6/R7/R8: full escalation, prescale 2
    wr(4'd1, 2); wr(4'd2, 5); wr(4'd3, 3); wr(4'd4, 4); wr(4'd5, 6); wr(4'd8, 1);
    rd_chk(4'd2, 5, "R1", "stage0 timeout readback");
    c = mk(1, 1, 2'd1, 2'd0, 2'd2, 2'd3, 3'd0, 3'd2);
    wr(4'd0, c); w = w_edge;
    push(0, w + 10, 0, "R3");
    push(1, w + 24, 8, "R4");
    push(2, w + 36, 24, "R8");
    rd_chk(4'd0, int'(c), "R1", "control readback");
    wait_until(w + 40);
    wr(4'd0, c & ~32'd1);
    wait_until(w + 62);
    chk(irq_o == 1'b1, "R6", "interrupt level held", int'(irq_o), 1);
    rd_chk(4'd9, 1, "R6", "raw bit set");
    rd_chk(4'd10, 1, "R6", "masked bit set");
    wr(4'd9, 1);
    chk(irq_o == 1'b0, "R6", "interrupt cleared", int'(irq_o), 0);
    rd_chk(4'd9, 0, "R6", "raw bit cleared");

    // R4: wrap with off stages, prescale 1
    wr(4'd1, 1); wr(4'd2, 20); wr(4'd3, 3); wr(4'd4, 3); wr(4'd5, 3);
    wr(4'd0, mk(1, 0, 2'd3, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0)); w = w_edge;
    push(2, w + 20, 8, "R4");
    push(2, w + 49, 8, "R4");
    wait_until(w + 60);
    wr(4'd0, 0);

    // R5: restart
    wr(4'd2, 10);
    wr(4'd0, mk(1, 0, 2'd3, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0)); w = w_edge;
    wait_until(w + 5);
    wr(4'd6, 32'h1234); f = w_edge;
    push(2, f + 10, 8, "R5");
    wait_until(f + 20);
    wr(4'd0, 0);

    // R7: CPU action gated off
    wr(4'd0, mk(1, 0, 2'd2, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0)); w = w_edge;
    v = 0;
    while (cyc < w + 14) begin
      @(negedge clk);
      if (cpu_rst_o) v++;
    end
    chk(v == 0, "R7", "CPU output with reset enable clear", v, 0);
    wr(4'd0, 0);

    // R7/R9: CPU action enabled, code 6
    wr(4'd0, mk(1, 1, 2'd2, 2'd0, 2'd0, 2'd0, 3'd6, 3'd0)); w = w_edge;
    push(1, w + 10, 128, "R7");
    wait_until(w + 12);
    wr(4'd0, 0);
    wait_until(w + 145);

    // R9: every system width code
    wr(4'd2, 4); wr(4'd3, 1000); wr(4'd4, 1000); wr(4'd5, 1000);
    for (int k = 0; k < 8; k++) begin
      wr(4'd0, mk(1, 0, 2'd3, 2'd0, 2'd0, 2'd0, 3'd0, 3'(k))); w = w_edge;
      push(2, w + 4, plen(k), "R9");
      wait_until(w + 4 + plen(k) + 2);
      wr(4'd0, 0);
    end

    // R6: masking
    wr(4'd8, 0);
    wr(4'd0, mk(1, 0, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0)); w = w_edge;
    wait_until(w + 6);
    wr(4'd0, 0);
    chk(irq_o == 1'b0, "R6", "masked interrupt output", int'(irq_o), 0);
    rd_chk(4'd9, 1, "R6", "raw set while masked");
    rd_chk(4'd10, 0, "R6", "masked status while disabled");
    wr(4'd8, 1);
    push(0, w_edge, 0, "R6");
    rd_chk(4'd10, 1, "R6", "masked status after enable");
    wr(4'd9, 1);
    chk(irq_o == 1'b0, "R6", "interrupt after clear", int'(irq_o), 0);
    wr(4'd8, 0);

    // R10: write protection
    wr(4'd2, 30);
    c = mk(1, 0, 2'd3, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0);
    wr(4'd0, c); w = w_edge;
    push(2, w + 30, 8, "R10");
    wr(4'd7, 0);
    rd_chk(4'd7, 0, "R10", "key accepted while unlocked");
    wr(4'd6, 0);
    wr(4'd1, 7);
    rd_chk(4'd1, 1, "R10", "prescale locked");
    wr(4'd0, 0);
    rd_chk(4'd0, int'(c), "R10", "control locked");
    wr(4'd2, 5);
    rd_chk(4'd2, 30, "R10", "timeout locked");
    wait_until(w + 45);
    wr(4'd7, 32'h50D83AA1);
    rd_chk(4'd7, 32'h50D83AA1, "R10", "key accepted while locked");
    wr(4'd0, 0);
    rd_chk(4'd0, 0, "R10", "control writable after unlock");

    repeat (20) @(negedge clk);
    chk(q_irq.size() == 0, "R6", "interrupt events outstanding", q_irq.size(), 0);
    chk(q_cpu.size() == 0, "R7", "CPU pulses outstanding", q_cpu.size(), 0);
    chk(q_sys.size() == 0, "R8", "system pulses outstanding", q_sys.size(), 0);
    summary();
  end

endmodule